// File: doc/BRIEF.md
# Single-Request Interrupt Concentrator

This block gathers 64 level-sensitive interrupt lines and presents at most one of them at a time as a single asserted bit on a 64-wide vector. Lines 0 to 31 come from expansion slots and are gated in groups of four. Lines 32 to 63 come from on-board devices and are gated one by one. Each gate is an enable flag held in a readable mapping register. The rest of each mapping register is a fixed identifier that writes never change.

Once a line is chosen it stays latched until software acknowledges it through a clear register, or turns off the mapping that covers it. There is one exception: a slot line that rises while its mapping is enabled takes over the latch at once, even when another request is held. On-board lines never take over. When nothing is latched, the lowest-numbered asserted and enabled line is chosen. Software reaches the registers through a plain single-cycle bus with a 16-bit offset, a write strobe and a combinational read path.

Top module: `irq_concentrator`

## Requirements
- R1: A synchronous reset clears every enable flag and the latched request, so the output vector is all zeros on the following cycle. The identifier bits of the mapping registers are not affected by reset.
- R2: Reading slot mapping register i (offset 0x0C00 + 8*i, i in 0..7) returns {enable, 0x7C0 | (i<<2)}. Reading on-board mapping register j (offset 0x1000 + 8*j) returns {enable, 0x7E0 + j}. Other offsets read 0. The enable is bit 31.
- R3: A write to a mapping register changes only bit 31. Bits 30:0 keep their fixed values.
- R4: A line can be latched only while its mapping is enabled. Slot line n uses slot register n/4, and on-board line n uses on-board register n-32.
- R5: When no request is latched, the design latches the lowest-numbered asserted and enabled line at the next clock edge. Every slot line therefore wins over every on-board line.
- R6: A latched request, and its output bit, stays put while its line drops or other lines assert, until it is cleared or preempted.
- R7: A slot line that rises while enabled replaces the latched request at the next edge; if several rise together, the lowest one wins. A rising on-board line never replaces a latched request.
- R8: A write to offset 0x1400-0x14FF selects slot group (offset[7:0])>>5. It clears the latch when the latched request is a slot line whose number divided by 4 equals that group.
- R9: A write to offset 0x1800-0x1860 selects line 32 + (offset[7:0]>>3). It clears the latch when that line is the one latched. Offsets past 0x1860 have no effect.
- R10: A mapping write with bit 31 = 0 clears the latch when the latched request belongs to that register.
- R11: In the cycle after a clear, the output is all zeros. Lines that are still pending are scanned again and latched one cycle later.
- R12: The output vector is one-hot with the latched line's bit set, or all zeros when nothing is latched.
- R13: The on-board mapping window is 0x1000-0x107F, so only on-board registers 0..15 are writable. A write at 0x1080 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 64 | Level interrupt lines; 0-31 slot, 32-63 on-board |
| bus_addr | input | 16 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| req_vec | output | 64 | One-hot latched request, zero when none |

## Verification
The bench checks the difference between the two groups. A rising slot line must preempt a held on-board or slot request, while a rising on-board line must be ignored. A design that treated both groups alike would either drop a held request or fail to preempt. It checks that a clear for a different group, or for an offset just past the on-board clear window, leaves the latch untouched; a loose address decode would clear it early. It checks that a cleared request returns only after a one-cycle gap and only if its line is still pending. It checks that disabling a mapping drops the latched request, and that a write cannot disturb the identifier bits.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NUM_IN     = 64;
    localparam int SLOT_IN    = 32;
    localparam int GROUP_SZ   = 4;
    localparam int SLOT_MAPS  = SLOT_IN / GROUP_SZ;
    localparam int BOARD_MAPS = NUM_IN - SLOT_IN;
    localparam int REQ_W      = $clog2(NUM_IN) + 1;
    localparam int IDX_W      = $clog2(BOARD_MAPS);
    localparam int SIDX_W     = $clog2(SLOT_MAPS);
    localparam int GRP_SH     = $clog2(GROUP_SZ);
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 32;
    localparam int EN_BIT     = DATA_W - 1;

    localparam logic [REQ_W-1:0] REQ_NONE = REQ_W'(NUM_IN);

    // register windows (inclusive bounds)
    localparam logic [ADDR_W-1:0] SMAP_LO = 16'h0C00;
    localparam logic [ADDR_W-1:0] SMAP_HI = 16'h0C3F;
    localparam logic [ADDR_W-1:0] BMAP_LO = 16'h1000;
    localparam logic [ADDR_W-1:0] BMAP_HI = 16'h107F;
    localparam logic [ADDR_W-1:0] SCLR_LO = 16'h1400;
    localparam logic [ADDR_W-1:0] SCLR_HI = 16'h14FF;
    localparam logic [ADDR_W-1:0] BCLR_LO = 16'h1800;
    localparam logic [ADDR_W-1:0] BCLR_HI = 16'h1860;

    localparam logic [DATA_W-2:0] ID_FILL  = 31'h7C0;
    localparam logic [DATA_W-2:0] ID_BOARD = 31'h020;

    typedef struct packed {
        logic             smap;
        logic             bmap;
        logic             sclr;
        logic             bclr;
        logic [IDX_W-1:0] idx;
    } bus_op_t;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_CLEAR,
        ACT_PREEMPT,
        ACT_SCAN
    } act_e;

    function automatic logic [DATA_W-2:0] slot_id(input logic [IDX_W-1:0] i);
        return ID_FILL | ((DATA_W-1)'(i) << GRP_SH);
    endfunction

    function automatic logic [DATA_W-2:0] board_id(input logic [IDX_W-1:0] j);
        return (ID_FILL | ID_BOARD) + (DATA_W-1)'(j);
    endfunction

    // lowest set bit index, REQ_NONE when empty
    function automatic logic [REQ_W-1:0] first_set(input logic [NUM_IN-1:0] v);
        logic [REQ_W-1:0] r;
        r = REQ_NONE;
        for (int i = NUM_IN - 1; i >= 0; i--) begin
            if (v[i]) r = REQ_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output bus_op_t           op
);
    always_comb begin
        op      = '0;
        op.smap = (addr >= SMAP_LO) && (addr <= SMAP_HI);
        op.bmap = (addr >= BMAP_LO) && (addr <= BMAP_HI);
        op.sclr = (addr >= SCLR_LO) && (addr <= SCLR_HI);
        op.bclr = (addr >= BCLR_LO) && (addr <= BCLR_HI);
        if (op.smap)
            op.idx = IDX_W'(addr[5:3]);
        else if (op.sclr)
            op.idx = IDX_W'(addr[7:5]);
        else
            op.idx = IDX_W'(addr[7:3]);
    end
endmodule

// File: rtl/irqc_map_regs.sv
module irqc_map_regs
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_op_t           op,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_IN-1:0] en_mask
);
    logic [SLOT_MAPS-1:0]  slot_en;
    logic [BOARD_MAPS-1:0] board_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_en  <= '0;
            board_en <= '0;
        end else if (we) begin
            if (op.smap) slot_en[op.idx[SIDX_W-1:0]] <= wdata[EN_BIT];
            if (op.bmap) board_en[op.idx]            <= wdata[EN_BIT];
        end
    end

    genvar g;
    generate
        for (g = 0; g < SLOT_IN; g++) begin : g_slot_en
            assign en_mask[g] = slot_en[g / GROUP_SZ];
        end
        for (g = 0; g < BOARD_MAPS; g++) begin : g_board_en
            assign en_mask[SLOT_IN + g] = board_en[g];
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (op.smap)
            rdata = {slot_en[op.idx[SIDX_W-1:0]], slot_id(op.idx)};
        else if (op.bmap)
            rdata = {board_en[op.idx], board_id(op.idx)};
    end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] irq_in,
    input  logic [NUM_IN-1:0] en_mask,
    input  bus_op_t           op,
    input  logic              we,
    input  logic              wr_en_bit,
    output logic [REQ_W-1:0]  req
);
    logic [SLOT_IN-1:0] slot_prev;
    logic [SLOT_IN-1:0] rise;
    logic [REQ_W-1:0]   pre_pick;
    logic [REQ_W-1:0]   scan_pick;
    logic               req_is_slot;
    logic               grp_match;
    logic               brd_match;
    logic               hit_clr;
    act_e               act;

    always_comb begin
        rise        = irq_in[SLOT_IN-1:0] & ~slot_prev & en_mask[SLOT_IN-1:0];
        pre_pick    = first_set(NUM_IN'(rise));
        scan_pick   = first_set(irq_in & en_mask);
        req_is_slot = req < REQ_W'(SLOT_IN);
        grp_match   = req_is_slot && ((req >> GRP_SH) == REQ_W'(op.idx));
        brd_match   = req == (REQ_W'(SLOT_IN) + REQ_W'(op.idx));
        hit_clr     = we && ((op.sclr && grp_match) ||
                             (op.bclr && brd_match) ||
                             (op.smap && !wr_en_bit && grp_match) ||
                             (op.bmap && !wr_en_bit && brd_match));
        if (hit_clr)
            act = ACT_CLEAR;
        else if (pre_pick != REQ_NONE)
            act = ACT_PREEMPT;
        else if (req == REQ_NONE && scan_pick != REQ_NONE)
            act = ACT_SCAN;
        else
            act = ACT_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req       <= REQ_NONE;
            slot_prev <= '0;
        end else begin
            slot_prev <= irq_in[SLOT_IN-1:0];
            case (act)
                ACT_CLEAR:   req <= REQ_NONE;
                ACT_PREEMPT: req <= pre_pick;
                ACT_SCAN:    req <= scan_pick;
                default:     req <= req;
            endcase
        end
    end
endmodule

// File: rtl/irq_concentrator.sv
module irq_concentrator
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] irq_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_IN-1:0] req_vec
);
    bus_op_t           op;
    logic [NUM_IN-1:0] en_mask;
    logic [REQ_W-1:0]  req;

    irqc_decode u_dec (
        .addr (bus_addr),
        .op   (op)
    );

    irqc_map_regs u_map (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .we      (bus_we),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .en_mask (en_mask)
    );

    irqc_arbiter u_arb (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq_in),
        .en_mask   (en_mask),
        .op        (op),
        .we        (bus_we),
        .wr_en_bit (bus_wdata[EN_BIT]),
        .req       (req)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_IN; g++) begin : g_vec
            assign req_vec[g] = (req == REQ_W'(g));
        end
    endgenerate
endmodule

module irqc_chk
    import irqc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [NUM_IN-1:0] irq_in,
    input logic              bus_we,
    input logic [NUM_IN-1:0] req_vec
);
    logic [SLOT_IN-1:0] seen_slot;
    logic               slot_rise;

    always_ff @(posedge clk) begin
        if (rst) seen_slot <= '0;
        else     seen_slot <= irq_in[SLOT_IN-1:0];
    end
    assign slot_rise = |(irq_in[SLOT_IN-1:0] & ~seen_slot);

    // R12
    onehot_vec_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_vec));

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (req_vec == '0));

    // R6
    hold_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (req_vec != '0 && !bus_we && !slot_rise) |=> $stable(req_vec));

    // R11
    clear_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        (req_vec != '0 && !bus_we) |=> (req_vec != '0));

    // R4
    new_req_from_line_chk: assert property (@(posedge clk) disable iff (rst)
        (req_vec != '0 && !$stable(req_vec)) |-> (($past(irq_in) & req_vec) != '0));
endmodule

bind irq_concentrator irqc_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .irq_in  (irq_in),
    .bus_we  (bus_we),
    .req_vec (req_vec)
);

// File: tb/sim_irq_concentrator.sv
module sim_irq_concentrator;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] irq_in = '0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [63:0] req_vec;

    int nchk  = 0;
    int nfail = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    irq_concentrator u0 (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq_in),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .req_vec   (req_vec)
    );

    localparam logic [63:0] L1  = 64'h1 << 1;
    localparam logic [63:0] L2  = 64'h1 << 2;
    localparam logic [63:0] L5  = 64'h1 << 5;
    localparam logic [63:0] L34 = 64'h1 << 34;
    localparam logic [31:0] EN  = 32'h8000_0000;
    localparam logic [6:0]  NO  = 7'd64;

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [31:0] wd;
        logic [63:0] irq;
        logic [6:0]  exp;
        logic [3:0]  rq;
    } step_t;

    localparam int NSTEP = 28;
    localparam step_t STEPS [NSTEP] = '{
        '{1'b0, 16'h0000, 32'h0, 64'h0,            NO,    4'd12}, // R12 idle
        '{1'b0, 16'h0000, 32'h0, L5,               NO,    4'd4 }, // R4 disabled
        '{1'b1, 16'h0C08, EN,    L5,               NO,    4'd4 }, // R4 enable lands next
        '{1'b0, 16'h0000, 32'h0, L5,               7'd5,  4'd5 }, // R5 scan
        '{1'b1, 16'h1010, EN,    L5 | L34,         7'd5,  4'd6 }, // R6
        '{1'b1, 16'h0C00, EN,    L5 | L34,         7'd5,  4'd6 },
        '{1'b0, 16'h0000, 32'h0, L1 | L5 | L34,    7'd1,  4'd7 }, // R7 preempt
        '{1'b1, 16'h1400, 32'h0, L1 | L5 | L34,    NO,    4'd8 }, // R8
        '{1'b0, 16'h0000, 32'h0, L1 | L5 | L34,    7'd1,  4'd11}, // R11 rescan
        '{1'b0, 16'h0000, 32'h0, L5 | L34,         7'd1,  4'd6 }, // R6 line dropped
        '{1'b1, 16'h1420, 32'h0, L5 | L34,         7'd1,  4'd8 }, // R8 other group
        '{1'b1, 16'h1400, 32'h0, L5 | L34,         NO,    4'd8 },
        '{1'b0, 16'h0000, 32'h0, L5 | L34,         7'd5,  4'd5 }, // R5 slot first
        '{1'b1, 16'h0C08, 32'h0, L5 | L34,         NO,    4'd10}, // R10
        '{1'b0, 16'h0000, 32'h0, L5 | L34,         7'd34, 4'd5 },
        '{1'b0, 16'h0000, 32'h0, L2 | L5 | L34,    7'd2,  4'd7 }, // R7 over board
        '{1'b1, 16'h1400, 32'h0, L2 | L5 | L34,    NO,    4'd8 },
        '{1'b0, 16'h0000, 32'h0, L5 | L34,         7'd34, 4'd11},
        '{1'b1, 16'h1818, 32'h0, L5 | L34,         7'd34, 4'd9 }, // R9 other line
        '{1'b1, 16'h1810, 32'h0, L5 | L34,         NO,    4'd9 }, // R9
        '{1'b0, 16'h0000, 32'h0, 64'h0,            NO,    4'd12},
        '{1'b1, 16'h0C08, EN,    L5,               NO,    4'd4 },
        '{1'b0, 16'h0000, 32'h0, L5,               7'd5,  4'd5 },
        '{1'b0, 16'h0000, 32'h0, L5 | L34,         7'd5,  4'd7 }, // R7 board no preempt
        '{1'b1, 16'h1420, 32'h0, L5 | L34,         NO,    4'd8 },
        '{1'b0, 16'h0000, 32'h0, L5 | L34,         7'd5,  4'd11},
        '{1'b1, 16'h1420, 32'h0, L34,              NO,    4'd8 },
        '{1'b0, 16'h0000, 32'h0, L34,              7'd34, 4'd5 }
    };

    task automatic chk_vec(input int r, input logic [6:0] e);
        logic [63:0] want;
        want = (e == NO) ? 64'h0 : (64'h1 << e);
        nchk++;
        if (req_vec !== want) begin
            nfail++;
            $display("FAIL R%0d req_vec actual=%h expected=%h", r, req_vec, want);
        end
    endtask

    task automatic chk_rd(input int r, input logic [15:0] a, input logic [31:0] e);
        bus_addr = a;
        bus_we   = 1'b0;
        #1;
        nchk++;
        if (bus_rdata !== e) begin
            nfail++;
            $display("FAIL R%0d read %h actual=%h expected=%h", r, a, bus_rdata, e);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000 && !done) begin
            nfail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state and identifier reads (R2)
        chk_vec(1, NO);
        chk_rd(2, 16'h0C18, 32'h0000_07CC);
        chk_rd(2, 16'h1028, 32'h0000_07E5);
        chk_rd(2, 16'h2000, 32'h0);

        // table walk
        for (int i = 0; i < NSTEP; i++) begin
            bus_addr  = STEPS[i].addr;
            bus_wdata = STEPS[i].wd;
            bus_we    = STEPS[i].we;
            irq_in    = STEPS[i].irq;
            @(posedge clk);
            @(negedge clk);
            bus_we = 1'b0;
            chk_vec(int'(STEPS[i].rq), STEPS[i].exp);
        end
        irq_in = '0;
        wr(16'h1010, 32'h0);
        wr(16'h0C00, 32'h0);
        wr(16'h0C08, 32'h0);

        // R3 write touches only bit 31
        wr(16'h0C18, 32'hFFFF_FFFF);
        chk_rd(3, 16'h0C18, 32'h8000_07CC);
        wr(16'h1028, 32'h7FFF_FFFF);
        chk_rd(3, 16'h1028, 32'h0000_07E5);

        // R1 reset clears latch and enables, keeps identifiers
        irq_in = 64'h1 << 12;
        idle();
        chk_vec(4, 7'd12);
        rst = 1'b1;
        idle();
        rst = 1'b0;
        chk_vec(1, NO);
        chk_rd(1, 16'h0C18, 32'h0000_07CC);
        idle();
        chk_vec(1, NO);
        irq_in = '0;

        // R13 on-board map window ends at 0x107F
        wr(16'h1080, EN);
        irq_in = 64'h1 << 48;
        idle();
        idle();
        chk_vec(13, NO);
        chk_rd(13, 16'h1080, 32'h0);
        irq_in = '0;

        // R9 on-board clear window boundary
        wr(16'h1060, EN);
        chk_rd(2, 16'h1060, 32'h8000_07EC);
        irq_in = 64'h1 << 44;
        idle();
        chk_vec(9, 7'd44);
        wr(16'h1868, 32'h0);
        chk_vec(9, 7'd44);
        irq_in = '0;
        wr(16'h1860, 32'h0);
        chk_vec(9, NO);
        idle();
        chk_vec(11, NO);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule